// File: doc/BRIEF.md
# Prioritised Event Interrupt Latch

This block collects pulses from eight numbered event sources into a sticky pending mask. It drives one fast-interrupt request line towards a processor, and it holds a current-event number that software reads to find out which source to service. The request line is high whenever at least one event is pending.

Software acknowledges events by pulsing a clear-write strobe. Writes are counted. Only every fourth write retires an event: the lowest pending bit is removed, and the current-event number moves to the next pending source above the retired one. When the mask becomes empty, the request line drops. Arrivals and retirements may happen in the same cycle, and no event is lost when they do.

All inputs are single-cycle control strobes and all outputs are plain registered status. There is no data stream at the edge, so there is no valid/ready handshake and no back-pressure.

Top module: `evt_irq_latch`

## Requirements
- R1: A synchronous active-high reset clears the pending mask, the current-event number, the interrupt line and the write counter. After reset, exactly four clear writes are needed for the first retirement.
- R2: A pulse on `evt_i[k]` sets bit k of `pend_o` one cycle later. A set bit stays set until a retirement removes it.
- R3: `irq_o` rises in the cycle after an event arrives into an empty mask. `irq_o` is high exactly when `pend_o` is non-zero.
- R4: An arriving event k replaces `cur_evt_o` when the held value is 0 or is greater than k. Events that arrive together are applied one after another in ascending index order, so a held 0 lets the next higher event of the same cycle replace it.
- R5: Each `clr_wr_i` pulse advances a modulo-4 counter. The first three writes of a group change no output. The fourth write acts and starts a new group, and it still starts a new group when the mask is empty.
- R6: The acting write clears only the lowest set bit of the pending mask.
- R7: After a retirement, `cur_evt_o` becomes the lowest bit still pending, which lies above the retired index. If no bit remains, `cur_evt_o` keeps its value.
- R8: `irq_o` falls in the cycle after a retirement empties the mask.
- R9: When an event pulse coincides with an acting clear write, the retirement is applied first and the new event is then recorded. The new bit therefore survives, and the line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 8 | Event pulses; bit k is event number k |
| clr_wr_i | input | 1 | One pulse per write to the acknowledge register |
| pend_o | output | 8 | Pending mask |
| cur_evt_o | output | 3 | Current-event number |
| irq_o | output | 1 | Fast-interrupt request |

## Verification
Single events are driven in rising, falling and repeated order. This separates the "replace when smaller" rule from a plain last-writer rule, and it exposes the case where a held 0 is overwritten by any later event. Groups of clear writes are issued both with events pending and with an empty mask. These show whether only every fourth write acts, whether the lowest bit goes first, and how the current number moves or holds. Coincident arrival-and-retire cycles, multi-bit event pulses and a reset in the middle of a counting group separate the ordering rules from each other.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned EVT_COUNT  = 8;
  localparam int unsigned ACK_GROUP  = 4;
  localparam int unsigned EVT_IDX_W  = $clog2(EVT_COUNT);
endpackage

// File: rtl/evt_lowest_set.sv
// Priority finder: reports the lowest set bit of a vector.
module evt_lowest_set #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign found_o = |vec_i;
endmodule

// File: rtl/evt_ack_count.sv
// Counts acknowledge writes; flags the write that completes a group.
module evt_ack_count #(
  parameter int unsigned GROUP = 4,
  localparam int unsigned CW   = (GROUP > 1) ? $clog2(GROUP) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  output logic fire_o
);
  logic [CW-1:0] cnt_q;

  assign fire_o = wr_i && (cnt_q == CW'(GROUP - 1));

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (fire_o)  cnt_q <= '0;
    else if (wr_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/evt_retire.sv
// Removes the lowest pending bit and selects the next one to present.
module evt_retire #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic [IW-1:0] cur_i,
  input  logic          fire_i,
  output logic [N-1:0]  pend_o,
  output logic [IW-1:0] cur_o
);
  logic          low_found;
  logic [IW-1:0] low_idx;
  logic          nxt_found;
  logic [IW-1:0] nxt_idx;
  logic [N-1:0]  low_mask;

  evt_lowest_set #(.N(N), .IW(IW)) u_low (
    .vec_i(pend_i), .found_o(low_found), .idx_o(low_idx)
  );

  always_comb begin
    low_mask = '0;
    if (low_found) low_mask[low_idx] = 1'b1;
  end

  assign pend_o = fire_i ? (pend_i & ~low_mask) : pend_i;

  // Remaining bits all lie above the removed one, so the lowest survivor
  // is the first hit of an upward scan from the retired index.
  evt_lowest_set #(.N(N), .IW(IW)) u_next (
    .vec_i(pend_o), .found_o(nxt_found), .idx_o(nxt_idx)
  );

  assign cur_o = (fire_i && low_found && nxt_found) ? nxt_idx : cur_i;
endmodule

// File: rtl/evt_arrive.sv
// Merges arriving pulses into the mask and updates the current number.
module evt_arrive #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  pend_i,
  input  logic [IW-1:0] cur_i,
  input  logic [N-1:0]  evt_i,
  output logic [N-1:0]  pend_o,
  output logic [IW-1:0] cur_o,
  output logic          raise_o
);
  always_comb begin
    cur_o = cur_i;
    for (int i = 0; i < N; i++) begin
      if (evt_i[i] && ((cur_o == '0) || (IW'(i) < cur_o))) cur_o = IW'(i);
    end
  end

  assign pend_o  = pend_i | evt_i;
  assign raise_o = (|evt_i) && !(|pend_i);
endmodule

// File: rtl/evt_irq_latch.sv
module evt_irq_latch
  import evt_irq_pkg::*;
#(
  parameter int unsigned NEVT  = EVT_COUNT,
  parameter int unsigned GROUP = ACK_GROUP,
  localparam int unsigned IW   = $clog2(NEVT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NEVT-1:0] evt_i,
  input  logic            clr_wr_i,
  output logic [NEVT-1:0] pend_o,
  output logic [IW-1:0]   cur_evt_o,
  output logic            irq_o
);
  logic [NEVT-1:0] pend_q, pend_ret, pend_nxt;
  logic [IW-1:0]   cur_q, cur_ret, cur_nxt;
  logic            irq_q, fire, raise;

  evt_ack_count #(.GROUP(GROUP)) u_cnt (
    .clk(clk), .rst(rst), .wr_i(clr_wr_i), .fire_o(fire)
  );

  evt_retire #(.N(NEVT), .IW(IW)) u_ret (
    .pend_i(pend_q), .cur_i(cur_q), .fire_i(fire),
    .pend_o(pend_ret), .cur_o(cur_ret)
  );

  evt_arrive #(.N(NEVT), .IW(IW)) u_arr (
    .pend_i(pend_ret), .cur_i(cur_ret), .evt_i(evt_i),
    .pend_o(pend_nxt), .cur_o(cur_nxt), .raise_o(raise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      cur_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      cur_q  <= cur_nxt;
      if (raise)                          irq_q <= 1'b1;
      else if (fire && !(|pend_ret))      irq_q <= 1'b0;
    end
  end

  assign pend_o    = pend_q;
  assign cur_evt_o = cur_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/evt_irq_latch_chk.sv
module evt_irq_latch_chk #(
  parameter int unsigned NEVT  = 8,
  parameter int unsigned GROUP = 4,
  parameter int unsigned IW    = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [NEVT-1:0] evt_i,
  input logic            clr_wr_i,
  input logic [NEVT-1:0] pend_o,
  input logic [IW-1:0]   cur_evt_o,
  input logic            irq_o
);
  localparam int unsigned CW = (GROUP > 1) ? $clog2(GROUP) : 1;
  logic [CW-1:0] wr_seen;

  always_ff @(posedge clk) begin
    if (rst) wr_seen <= '0;
    else if (clr_wr_i) wr_seen <= (wr_seen == CW'(GROUP - 1)) ? '0 : wr_seen + 1'b1;
  end

  a_r3_irq_follows_mask: assert property (@(posedge clk) disable iff (rst)
    irq_o == (pend_o != '0));

  a_r2_event_sets_bit: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((pend_o & $past(evt_i)) == $past(evt_i)));

  a_r2_sticky_without_write: assert property (@(posedge clk) disable iff (rst)
    !clr_wr_i |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

  a_r5_early_writes_inert: assert property (@(posedge clk) disable iff (rst)
    (clr_wr_i && (wr_seen != CW'(GROUP - 1))) |=>
      ((pend_o & $past(pend_o)) == $past(pend_o)));

  a_r6_one_bit_per_retire: assert property (@(posedge clk) disable iff (rst)
    clr_wr_i |=> ($countones($past(pend_o) & ~pend_o) <= 1));

  a_r4_current_stable_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!clr_wr_i && (evt_i == '0)) |=> $stable(cur_evt_o));
endmodule

bind evt_irq_latch evt_irq_latch_chk #(.NEVT(NEVT), .GROUP(GROUP), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .clr_wr_i(clr_wr_i),
  .pend_o(pend_o), .cur_evt_o(cur_evt_o), .irq_o(irq_o)
);

// File: tb/tb_evt_irq_latch.sv
`timescale 1ns/1ps
module tb_evt_irq_latch;
  typedef struct {
    logic [7:0] pend;
    logic [2:0] cur;
    logic       irq;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] evt_i = '0;
  logic       clr_wr_i = 1'b0;
  logic [7:0] pend_o;
  logic [2:0] cur_evt_o;
  logic       irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t q[$];

  // reference state
  logic [7:0] m_p;
  logic [2:0] m_c;
  int         m_k;
  logic       m_irq;

  always #10 clk = ~clk;

  evt_irq_latch dut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .clr_wr_i(clr_wr_i),
    .pend_o(pend_o), .cur_evt_o(cur_evt_o), .irq_o(irq_o)
  );

  // Monitor: compares a quarter period after each rising edge.
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (pend_o !== e.pend || cur_evt_o !== e.cur || irq_o !== e.irq) begin
        n_bad++;
        $display("FAIL %s: got pend=%h cur=%0d irq=%b, expected pend=%h cur=%0d irq=%b",
                 e.tag, pend_o, cur_evt_o, irq_o, e.pend, e.cur, e.irq);
      end
    end
  end

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; evt_i = '0; clr_wr_i = 1'b0;
    m_p = '0; m_c = '0; m_k = 0; m_irq = 1'b0;
    q.push_back('{m_p, m_c, m_irq, tag});
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Driver: applies one cycle of stimulus and predicts the result.
  task automatic step(input logic [7:0] ev, input logic wr, input string tag);
    bit act;
    @(negedge clk);
    evt_i = ev; clr_wr_i = wr;
    act = 1'b0;
    if (wr) begin
      if (m_k == 3) begin m_k = 0; act = 1'b1; end
      else m_k = m_k + 1;
    end
    if (act) begin
      int pos;
      pos = 8;
      for (int i = 0; i < 8; i++) if (pos == 8 && m_p[i]) pos = i;
      if (pos < 8) begin
        int j;
        m_p[pos] = 1'b0;
        for (j = pos; j < 8; j++) if (m_p[j]) break;
        if (j < 8) m_c = 3'(j);
      end
      if (m_p == '0) m_irq = 1'b0;
    end
    for (int i = 0; i < 8; i++) begin
      if (ev[i]) begin
        if (m_p == '0) m_irq = 1'b1;
        m_p[i] = 1'b1;
        if (m_c == 0 || i < int'(m_c)) m_c = 3'(i);
      end
    end
    q.push_back('{m_p, m_c, m_irq, tag});
  endtask

  task automatic acks(input int n, input string tag);
    for (int i = 0; i < n; i++) step('0, 1'b1, tag);
  endtask

  initial begin
    do_reset("R1 reset state");
    step(8'h20, 1'b0, "R3 first event raises line");
    step(8'h08, 1'b0, "R4 smaller event replaces");
    step(8'h40, 1'b0, "R4 larger event kept out");
    step(8'h20, 1'b0, "R2 repeated event sticky");
    acks(3, "R5 early writes inert");
    step('0, 1'b1, "R6 fourth write clears lowest");
    acks(4, "R7 next pending presented");
    acks(4, "R8 line falls on empty mask");
    step(8'h01, 1'b0, "R4 event 0 replaces");
    step(8'h10, 1'b0, "R4 held zero overwritten");
    acks(4, "R7 scan upward from retired");
    acks(3, "R5 counting toward coincidence");
    step(8'h04, 1'b1, "R9 event survives retire");
    acks(4, "R8 retire last bit");
    acks(4, "R5 group on empty mask");
    step(8'h0A, 1'b0, "R4 simultaneous events ascending");
    step(8'h81, 1'b0, "R4 zero then higher same cycle");
    acks(2, "R5 partial group");
    do_reset("R1 reset mid group");
    step(8'h30, 1'b0, "R2 two bits at once");
    acks(3, "R1 counter restarted");
    step('0, 1'b1, "R6 retire after reset");
    step('0, 1'b0, "R7 idle hold");
    @(negedge clk);
    evt_i = '0; clr_wr_i = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    if (q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: got %0d pending, expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule